// File: doc/BRIEF.md
# Multi-Core Mailbox Doorbell Unit

This block gives a four-core cluster a set of doorbells for signalling between processors. Every core owns four 32-bit mailboxes. A master that wants to signal a core writes ones to that mailbox's set address. The target core acknowledges by writing ones to the matching clear address. Because setting and clearing go through separate addresses, neither side ever needs a read-modify-write, so a doorbell raised while another is being acknowledged is never lost.

Each core has an 8-bit enable register. It steers any of its four mailboxes onto the core's normal interrupt line, its fast interrupt line, or both. The block also exposes a per-core vector of pending mailboxes. Writes arrive on a parameterised number of independent write ports, so two masters can reach the same mailbox in one cycle. A single combinational read port returns mailbox contents and enable registers. All addresses are byte offsets.

Top module: `doorbell_mbox`

## Requirements
- R1: While reset is held low, every mailbox and every enable register is zero. The irq_o, fiq_o and pend_o outputs are then all low.
- R2: A write to byte offset 0x80 + 16*c + 4*m ORs the ones of the write data into mailbox m of core c. The new value is visible on the next clock.
- R3: A write to byte offset 0xC0 + 16*c + 4*m clears those bits of mailbox m of core c that are one in the write data. Clearing a single bit leaves the mailbox's other set bits, and its pending state, intact.
- R4: rd_data is combinational from rd_addr. At a clear offset it returns the mailbox's current 32-bit value. At an enable offset it returns the enable register in bits 7:0, with zeros above. Every other offset reads zero.
- R5: The enable register of core c sits at byte offset 0x50 + 4*c. Bit m routes mailbox m to irq_o[c] and bit m+4 routes it to fiq_o[c]. irq_o[c] is high when any mailbox of core c that has a routing bit set on that line is nonzero, and fiq_o[c] works the same way on its own bits.
- R6: pend_o[4*c + m] is high exactly when mailbox m of core c is nonzero and at least one of its two enable bits is set.
- R7: When one port sets a bit and another port clears the same bit in the same cycle, the bit ends up set.
- R8: Bits written as zero to a set or clear offset leave the mailbox unchanged.
- R9: A write whose offset is not word-aligned, or is not a set, clear or enable offset, changes no state.
- R10: Several ports may write in the same cycle. Their set bits are OR-combined and their clear bits are OR-combined. When more than one port writes the same enable register, the highest-numbered port's data is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | NPORT | Write strobe per port |
| wr_addr | input | 8*NPORT | Byte offset per port, port p in bits 8p+7:8p |
| wr_data | input | 32*NPORT | Write data per port, port p in bits 32p+31:32p |
| rd_addr | input | 8 | Byte offset for the read port |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 4 | Normal interrupt line per core |
| fiq_o | output | 4 | Fast interrupt line per core |
| pend_o | output | 16 | Pending mailbox vector, bit 4c+m for mailbox m of core c |

## Verification
The assertions assume reset is asserted before the first active edge and that the write inputs are stable at each rising edge. They also assume each port's data is meaningful only while its strobe is high. They make no assumption about address legality, because misaligned and unmapped offsets must fall through as no-ops.

The bench drives inputs one time unit after each rising edge. That keeps every strobe stable across the next edge. Its random phase uses only 4-byte-aligned offsets, but the directed phase deliberately issues misaligned and unmapped writes, and also same-cycle set and clear collisions on one bit.

// File: rtl/doorbell_mbox.sv
module doorbell_mbox #(
  parameter int NPORT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   wr_en,
  input  logic [NPORT*8-1:0] wr_addr,
  input  logic [NPORT*32-1:0] wr_data,
  input  logic [7:0]         rd_addr,
  output logic [31:0]        rd_data,
  output logic [3:0]         irq_o,
  output logic [3:0]         fiq_o,
  output logic [15:0]        pend_o
);
  localparam int NCORE = 4;
  localparam int NMBX  = 4;
  localparam int NBOX  = NCORE * NMBX;
  localparam int DW    = 32;
  localparam int AW    = 8;

  logic [DW-1:0] mbox   [NBOX];
  logic [DW-1:0] set_m  [NBOX];
  logic [DW-1:0] clr_m  [NBOX];
  logic [7:0]    cfg    [NCORE];
  logic [7:0]    cfg_nx [NCORE];
  logic [NCORE-1:0] cfg_we;
  logic [NBOX-1:0]  nz;

  always_comb begin
    for (int i = 0; i < NBOX; i++) begin
      set_m[i] = '0;
      clr_m[i] = '0;
    end
    for (int c = 0; c < NCORE; c++) cfg_nx[c] = cfg[c];
    cfg_we = '0;
    for (int p = 0; p < NPORT; p++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = wr_addr[p*AW +: AW];
      d = wr_data[p*DW +: DW];
      if (wr_en[p] && a[1:0] == 2'b00) begin
        if (a[7:6] == 2'b10)      set_m[a[5:2]] = set_m[a[5:2]] | d;
        else if (a[7:6] == 2'b11) clr_m[a[5:2]] = clr_m[a[5:2]] | d;
        else if (a[7:4] == 4'h5) begin
          cfg_we[a[3:2]] = 1'b1;
          cfg_nx[a[3:2]] = d[7:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBOX; i++) mbox[i] <= '0;
      for (int c = 0; c < NCORE; c++) cfg[c] <= '0;
    end else begin
      for (int i = 0; i < NBOX; i++) mbox[i] <= (mbox[i] & ~clr_m[i]) | set_m[i];
      for (int c = 0; c < NCORE; c++) if (cfg_we[c]) cfg[c] <= cfg_nx[c];
    end
  end

  genvar gi, gc;
  generate
    for (gi = 0; gi < NBOX; gi++) begin : g_box
      assign nz[gi]     = |mbox[gi];
      assign pend_o[gi] = nz[gi] & (cfg[gi/NMBX][gi%NMBX] | cfg[gi/NMBX][gi%NMBX+NMBX]);

      AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m[gi] != '0) |=> ((mbox[gi] & $past(set_m[gi])) == $past(set_m[gi]))); // R7
      AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m[gi] != '0) |=> ((mbox[gi] & $past(clr_m[gi] & ~set_m[gi])) == '0)); // R3
      AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((mbox[gi] ^ $past(mbox[gi])) & ~$past(set_m[gi] | clr_m[gi])) == '0)); // R8
      AST_EMPTY_NOT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox[gi] == '0) |-> !pend_o[gi]); // R6
    end
    for (gc = 0; gc < NCORE; gc++) begin : g_core
      assign irq_o[gc] = |(nz[gc*NMBX +: NMBX] & cfg[gc][NMBX-1:0]);
      assign fiq_o[gc] = |(nz[gc*NMBX +: NMBX] & cfg[gc][2*NMBX-1:NMBX]);

      AST_LINE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o[gc] | fiq_o[gc]) |-> (pend_o[gc*NMBX +: NMBX] != '0)); // R5
      AST_CFG_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we[gc] |=> $stable(cfg[gc])); // R9
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_addr[7:6] == 2'b11)     rd_data = mbox[rd_addr[5:2]];
      else if (rd_addr[7:4] == 4'h5) rd_data = {24'd0, cfg[rd_addr[3:2]]};
    end
  end
endmodule

// File: tb/test_doorbell_mbox.sv
module test_doorbell_mbox;
  localparam int PERIOD = 10;
  localparam int NP = 2;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] wr_en = '0;
  logic [NP*8-1:0] wr_addr = '0;
  logic [NP*32-1:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0] irq_o, fiq_o;
  logic [15:0] pend_o;

  int tests = 0, fails = 0;
  bit done = 0;

  doorbell_mbox #(.NPORT(NP)) i_doorbell_mbox (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .irq_o, .fiq_o, .pend_o);

  always #(PERIOD/2) clk = ~clk;

  logic [31:0] m_mb [16];
  logic [7:0]  m_cfg [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_mb[i] = 0;
      for (int c = 0; c < 4; c++) m_cfg[c] = 0;
    end else begin
      logic [31:0] sm [16];
      logic [31:0] cm [16];
      for (int i = 0; i < 16; i++) begin sm[i] = 0; cm[i] = 0; end
      for (int p = 0; p < NP; p++) begin
        int a;
        logic [31:0] d;
        a = int'(wr_addr[p*8 +: 8]);
        d = wr_data[p*32 +: 32];
        if (wr_en[p] && a % 4 == 0) begin
          if (a >= 128 && a < 192) sm[(a-128)/4] |= d;
          else if (a >= 192) cm[(a-192)/4] |= d;
          else if (a >= 80 && a < 96) m_cfg[(a-80)/4] = d[7:0];
        end
      end
      for (int i = 0; i < 16; i++) m_mb[i] = (m_mb[i] & ~cm[i]) | sm[i];
    end
  end

  function automatic logic [31:0] exp_rd(int a);
    if (a % 4 != 0) return 0;
    if (a >= 192) return m_mb[(a-192)/4];
    if (a >= 80 && a < 96) return {24'd0, m_cfg[(a-80)/4]};
    return 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs();
    logic [15:0] ep;
    logic [3:0] ei, ef;
    ep = 0; ei = 0; ef = 0;
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        bit full;
        full = (m_mb[c*4+m] != 0);
        if (full && (m_cfg[c][m] || m_cfg[c][m+4])) ep[c*4+m] = 1;
        if (full && m_cfg[c][m]) ei[c] = 1;
        if (full && m_cfg[c][m+4]) ef[c] = 1;
      end
    check("R6 pend_o", {16'd0, pend_o}, {16'd0, ep});
    check("R5 irq_o", {28'd0, irq_o}, {28'd0, ei});
    check("R5 fiq_o", {28'd0, fiq_o}, {28'd0, ef});
    check("R4 rd_data", rd_data, exp_rd(int'(rd_addr)));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    check_outs();
    wr_en = '0;
  endtask

  task automatic wr(int p, int a, logic [31:0] d);
    wr_en[p] = 1'b1;
    wr_addr[p*8 +: 8] = a[7:0];
    wr_data[p*32 +: 32] = d;
  endtask

  task automatic rd(string tag, int a, logic [31:0] exp);
    rd_addr = a[7:0];
    #1;
    check(tag, rd_data, exp);
    check(tag, rd_data, exp_rd(a));
  endtask

  function automatic int sa(int c, int m); return 128 + c*16 + m*4; endfunction
  function automatic int ca(int c, int m); return 192 + c*16 + m*4; endfunction

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 pend_o", {16'd0, pend_o}, 0);
    check("R1 irq_o", {28'd0, irq_o}, 0);
    check("R1 fiq_o", {28'd0, fiq_o}, 0);
    rst_n = 1;
    rd("R1 mailbox", ca(2, 1), 0);

    wr(0, 80 + 4, 32'h0000_0012);
    tick();
    rd("R5 cfg read", 84, 32'h12);
    wr(0, sa(1, 1), 32'h0000_0005);
    tick();
    rd("R2 set", ca(1, 1), 32'h5);
    check("R5 irq core1", {31'd0, irq_o[1]}, 1);
    check("R5 fiq core1", {31'd0, fiq_o[1]}, 0);
    wr(1, sa(1, 1), 32'h8000_0000);
    tick();
    rd("R2 or", ca(1, 1), 32'h8000_0005);

    wr(0, ca(1, 1), 32'h0000_0001);
    tick();
    rd("R3 single clear", ca(1, 1), 32'h8000_0004);
    check("R3 still pend", {31'd0, pend_o[5]}, 1);
    wr(0, ca(1, 1), 32'h8000_0004);
    tick();
    check("R3 drained", {31'd0, pend_o[5]}, 0);

    wr(0, sa(3, 2), 32'h0000_00F0);
    tick();
    wr(0, sa(3, 2), 32'h0);
    wr(1, ca(3, 2), 32'h0);
    tick();
    rd("R8 zero data", ca(3, 2), 32'hF0);

    wr(0, ca(3, 2), 32'h0000_0010);
    wr(1, sa(3, 2), 32'h0000_0010);
    tick();
    rd("R7 set wins", ca(3, 2), 32'hF0);
    wr(1, ca(3, 2), 32'h0000_0020);
    wr(0, sa(3, 2), 32'h0000_0020);
    tick();
    rd("R7 set wins p0", ca(3, 2), 32'hF0);

    wr(0, sa(0, 0) + 1, 32'hFFFF_FFFF);
    wr(1, 8'h40, 32'hFFFF_FFFF);
    tick();
    rd("R9 misaligned", ca(0, 0), 0);
    rd("R9 misaligned read", ca(3, 2) + 2, 0);
    rd("R9 unmapped read", 8'h40, 0);
    wr(0, 80 + 1, 32'hFF);
    tick();
    rd("R9 cfg misaligned", 80, 0);

    wr(0, 80 + 12, 32'h0F);
    wr(1, 80 + 12, 32'h40);
    tick();
    rd("R10 cfg high port", 92, 32'h40);
    check("R5 fiq core3", {31'd0, fiq_o[3]}, 1);
    check("R5 irq core3", {31'd0, irq_o[3]}, 0);
    rd("R4 set addr reads zero", sa(3, 2), 0);

    for (int k = 0; k < 400; k++) begin
      for (int p = 0; p < NP; p++) begin
        int kind, c, m;
        kind = int'($urandom_range(0, 9));
        c = int'($urandom_range(0, 3));
        m = int'($urandom_range(0, 3));
        if ($urandom_range(0, 2) != 0) begin
          if (kind < 4) wr(p, sa(c, m), 32'd1 << $urandom_range(0, 31));
          else if (kind < 8) wr(p, ca(c, m), 32'd1 << $urandom_range(0, 31));
          else if (kind == 8) wr(p, 80 + c*4, {24'd0, 8'($urandom)});
          else wr(p, 4*int'($urandom_range(0, 63)), $urandom);
        end
      end
      rd_addr = 8'(4 * $urandom_range(0, 63));
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule